// File: doc/BRIEF.md
# Masked Address/Data Breakpoint Comparator

This block is one hardware breakpoint unit. It watches a stream of access events and flags the ones that should stop the processor. Each event gives an address, a 32-bit data value, an event class (fetch, memory or I/O) and a direction (read or write). The event address is compared with a breakpoint address. A 12-bit don't-care mask lets one breakpoint cover an aligned window of up to 4096 addresses. For data breakpoints the unit can also compare the event data with a match value under a 32-bit don't-care mask. It can hit on equality or on inequality, filter by direction, or ignore the address altogether.

Four configuration registers hold the settings: a mode value, the data match, the data mask and the address mask. They sit behind a register port that only opens when a 32-bit key is presented. The breakpoint address, its 2-bit type, its local and global enables and the debug-extensions enable come in as plain inputs. The result is a single-cycle `hit` pulse one clock after the event that matched.

Top module: `bp_match_unit`

## Requirements
- R1: After reset, all four configuration registers read back as zero and `hit` is low.
- R2: A configuration read or write succeeds only when `cfgKey` equals 0x9C5A203A. Any other key raises `cfgFault` on the next clock, leaves the registers unchanged and returns zero on `cfgRdata`. Select codes: 0 mode (8 bits), 1 data match, 2 data mask, 3 address mask (12 bits). Narrow registers read back zero-extended.
- R3: In both masks a 1 bit is excluded from the compare. A zero mask demands an exact match. An address mask of 0xFFF accepts any address in the same aligned 4096-address block. A data mask of all ones makes the data compare always succeed.
- R4: The breakpoint can hit only when `bpLocalEn` or `bpGlobalEn` is 1. An I/O breakpoint (`bpKind`=2'b10) also needs `dbgExtEn`=1.
- R5: An execute breakpoint (`bpKind`=2'b00) hits on a fetch event (`accKind`=2'b00) whose address matches under the address mask. The mode value and the data registers have no effect on it.
- R6: With mode 0, no data compare is made. A memory breakpoint of type 2'b01 hits only on writes, and one of type 2'b11 hits on reads and writes. An I/O breakpoint hits on either direction.
- R7: With mode 2, a data breakpoint hits only on writes, even for type 2'b11. It also needs the address to match and the masked data to equal the match value.
- R8: Mode 3 is the same as mode 2, except that the masked data must differ from the match value.
- R9: With mode 1, a data breakpoint hits on any write whose masked data matches, whatever the address.
- R10: For an I/O breakpoint, modes 8 and 9 hit only on reads, and the address must match. Mode 8 needs the data to match. Mode 9 needs the data to differ.
- R11: For a memory breakpoint, bit 3 of the mode is ignored: 8 acts as 0 and 9 acts as 1.
- R12: `hit` is a one-cycle pulse, registered, one clock after the event is sampled with `accValid`=1. Mode values not listed above act as mode 0.
- R13: An event counts only if its class matches the breakpoint: fetch (`accKind`=2'b00) for execute, memory (2'b01) for types 2'b01 and 2'b11, and I/O (2'b10) for type 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration access request |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgSel | input | 2 | Register select |
| cfgKey | input | 32 | Access key |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data, one clock after request |
| cfgFault | output | 1 | Key mismatch, one clock after request |
| bpAddr | input | 32 | Breakpoint address |
| bpKind | input | 2 | Breakpoint type: 00 execute, 01 memory write, 10 I/O, 11 memory read/write |
| bpLocalEn | input | 1 | Local enable |
| bpGlobalEn | input | 1 | Global enable |
| dbgExtEn | input | 1 | Debug-extensions enable (needed for I/O) |
| accValid | input | 1 | Access event valid |
| accAddr | input | 32 | Event address |
| accData | input | 32 | Event data |
| accKind | input | 2 | Event class: 00 fetch, 01 memory, 10 I/O |
| accWrite | input | 1 | Event direction, 1 = write |
| hit | output | 1 | Breakpoint hit pulse |

## Verification
The hardest thing to reach from the ports is the point where modes diverge. The same address and data must hit under one mode and miss under another: address ignored or applied, data equal or inverted, bit 3 aliased for memory but meaningful for I/O. The stimulus therefore keeps the address and data vectors fixed and rewrites only the mode register between short bursts, so the mode alone changes the outcome. Every expected hit goes through a queue keyed on the cycle it is due, and each idle cycle in between must show `hit` low.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_MEM   = 2'b01,
    ACC_IO    = 2'b10,
    ACC_RSVD  = 2'b11
  } accKindT;

  localparam logic [1:0] BP_EXEC = 2'b00;
  localparam logic [1:0] BP_WR   = 2'b01;
  localparam logic [1:0] BP_IO   = 2'b10;
  localparam logic [1:0] BP_RW   = 2'b11;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_MATCH = 2'd1;
  localparam logic [1:0] SEL_DMASK = 2'd2;
  localparam logic [1:0] SEL_AMASK = 2'd3;

  // strobes from the control side to the compare datapath
  typedef struct packed {
    logic       armed;
    logic [1:0] needKind;
    logic       useAddr;
    logic       useData;
    logic       invData;
    logic       onRead;
    logic       onWrite;
  } modeStrbT;
endpackage

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMASK_W = 12,
  parameter int CTL_W   = 8,
  parameter logic [31:0] ACCESS_KEY = 32'h9C5A_203A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic               cfgWrite,
  input  logic [1:0]         cfgSel,
  input  logic [31:0]        cfgKey,
  input  logic [DATA_W-1:0]  cfgWdata,
  output logic [DATA_W-1:0]  cfgRdata,
  output logic               cfgFault,
  input  logic [1:0]         bpKind,
  input  logic               bpLocalEn,
  input  logic               bpGlobalEn,
  input  logic               dbgExtEn,
  output logic [DATA_W-1:0]  matchVal,
  output logic [DATA_W-1:0]  dataMask,
  output logic [AMASK_W-1:0] addrMask,
  output modeStrbT           strb
);
  localparam int CTL_PAD = DATA_W - CTL_W;
  localparam int AM_PAD  = DATA_W - AMASK_W;

  logic [CTL_W-1:0] modeReg;
  logic [CTL_W-1:0] effMode;
  logic             keyOk;
  logic             isIo;

  assign keyOk = (cfgKey == ACCESS_KEY);
  assign isIo  = (bpKind == BP_IO);

  // register file behind the key
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      matchVal <= '0;
      dataMask <= '0;
      addrMask <= '0;
      cfgRdata <= '0;
      cfgFault <= 1'b0;
    end else begin
      cfgFault <= cfgValid && !keyOk;
      cfgRdata <= '0;
      if (cfgValid && keyOk) begin
        if (cfgWrite) begin
          case (cfgSel)
            SEL_MODE:  modeReg  <= cfgWdata[CTL_W-1:0];
            SEL_MATCH: matchVal <= cfgWdata;
            SEL_DMASK: dataMask <= cfgWdata;
            default:   addrMask <= cfgWdata[AMASK_W-1:0];
          endcase
        end else begin
          case (cfgSel)
            SEL_MODE:  cfgRdata <= {{CTL_PAD{1'b0}}, modeReg};
            SEL_MATCH: cfgRdata <= matchVal;
            SEL_DMASK: cfgRdata <= dataMask;
            default:   cfgRdata <= {{AM_PAD{1'b0}}, addrMask};
          endcase
        end
      end
    end
  end

  // bit 3 of the mode only means something for I/O breakpoints
  always_comb begin
    effMode    = modeReg;
    effMode[3] = isIo ? modeReg[3] : 1'b0;
  end

  // mode decode into datapath strobes
  always_comb begin
    strb.armed    = (bpLocalEn || bpGlobalEn) && (!isIo || dbgExtEn);
    strb.useAddr  = 1'b1;
    strb.useData  = 1'b0;
    strb.invData  = 1'b0;
    strb.onRead   = 1'b1;
    strb.onWrite  = 1'b1;
    if (bpKind == BP_EXEC) begin
      strb.needKind = ACC_FETCH;
    end else begin
      strb.needKind = isIo ? ACC_IO : ACC_MEM;
      strb.onRead   = (bpKind != BP_WR);
      case (effMode)
        CTL_W'(1): begin
          strb.useAddr = 1'b0;
          strb.useData = 1'b1;
          strb.onRead  = 1'b0;
        end
        CTL_W'(2), CTL_W'(3): begin
          strb.useData = 1'b1;
          strb.invData = effMode[0];
          strb.onRead  = 1'b0;
        end
        CTL_W'(8), CTL_W'(9): begin
          strb.useData = 1'b1;
          strb.invData = effMode[0];
          strb.onRead  = 1'b1;
          strb.onWrite = 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_fault_on_bad_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && cfgKey != ACCESS_KEY) |=> cfgFault);

  assert_regs_kept_on_bad_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && cfgWrite && cfgKey != ACCESS_KEY) |=>
      ($stable(modeReg) && $stable(matchVal) && $stable(dataMask) && $stable(addrMask)));

  assert_mem_never_read_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bpKind != BP_IO) |-> !(strb.onRead && !strb.onWrite));

  assert_no_addr_needs_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.useAddr |-> (strb.useData && !strb.onRead));
endmodule

// File: rtl/bpm_dp.sv
module bpm_dp
  import bpm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int AMASK_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [DATA_W-1:0]  accData,
  input  logic [1:0]         accKind,
  input  logic               accWrite,
  input  logic [ADDR_W-1:0]  bpAddr,
  input  logic [DATA_W-1:0]  matchVal,
  input  logic [DATA_W-1:0]  dataMask,
  input  logic [AMASK_W-1:0] addrMask,
  input  modeStrbT           strb,
  output logic               hit
);
  logic [ADDR_W-1:0] addrBitOk;
  logic [DATA_W-1:0] dataBitOk;
  logic addrOk, dataOk, dirOk, kindOk, fire;

  for (genvar g = 0; g < ADDR_W; g++) begin : gAddrBit
    if (g < AMASK_W) begin : gMasked
      assign addrBitOk[g] = (accAddr[g] == bpAddr[g]) | addrMask[g];
    end else begin : gExact
      assign addrBitOk[g] = (accAddr[g] == bpAddr[g]);
    end
  end

  assign dataBitOk = ~(accData ^ matchVal) | dataMask;
  assign addrOk    = &addrBitOk;
  assign dataOk    = &dataBitOk;
  assign dirOk     = accWrite ? strb.onWrite : strb.onRead;
  assign kindOk    = (accKind == strb.needKind);
  assign fire      = accValid && strb.armed && kindOk && dirOk &&
                     (!strb.useAddr || addrOk) &&
                     (!strb.useData || (dataOk ^ strb.invData));

  always_ff @(posedge clk) begin
    if (!rstN) hit <= 1'b0;
    else       hit <= fire;
  end

  assert_hit_after_event_R12: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(accValid));

  assert_hit_needs_arm_R4: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(strb.armed));

  assert_hit_class_R13: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(accKind == strb.needKind));

  assert_write_only_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> !$past(strb.onWrite && !strb.onRead && !accWrite));
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
  import bpm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int AMASK_W = 12,
  parameter int CTL_W   = 8,
  parameter logic [31:0] ACCESS_KEY = 32'h9C5A_203A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgSel,
  input  logic [31:0]       cfgKey,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] cfgRdata,
  output logic              cfgFault,
  input  logic [ADDR_W-1:0] bpAddr,
  input  logic [1:0]        bpKind,
  input  logic              bpLocalEn,
  input  logic              bpGlobalEn,
  input  logic              dbgExtEn,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic [1:0]        accKind,
  input  logic              accWrite,
  output logic              hit
);
  logic [DATA_W-1:0]  matchVal;
  logic [DATA_W-1:0]  dataMask;
  logic [AMASK_W-1:0] addrMask;
  modeStrbT           strb;

  bpm_ctrl #(
    .DATA_W(DATA_W), .AMASK_W(AMASK_W), .CTL_W(CTL_W), .ACCESS_KEY(ACCESS_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgKey(cfgKey),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfgFault(cfgFault),
    .bpKind(bpKind), .bpLocalEn(bpLocalEn), .bpGlobalEn(bpGlobalEn), .dbgExtEn(dbgExtEn),
    .matchVal(matchVal), .dataMask(dataMask), .addrMask(addrMask), .strb(strb)
  );

  bpm_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AMASK_W(AMASK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accAddr(accAddr), .accData(accData),
    .accKind(accKind), .accWrite(accWrite),
    .bpAddr(bpAddr), .matchVal(matchVal), .dataMask(dataMask), .addrMask(addrMask),
    .strb(strb), .hit(hit)
  );
endmodule

// File: tb/bp_match_unit_tb.sv
`timescale 1ns/1ps
module bp_match_unit_tb;
  localparam logic [31:0] KEY = 32'h9C5A_203A;
  localparam logic [31:0] BPA = 32'h0001_2340;
  localparam logic [31:0] MV  = 32'hDEAD_BEEF;
  localparam logic [1:0] K_F = 2'b00, K_M = 2'b01, K_I = 2'b10;
  localparam logic [1:0] T_X = 2'b00, T_W = 2'b01, T_IO = 2'b10, T_RW = 2'b11;

  logic clk = 0, rstN = 0;
  logic cfgValid = 0, cfgWrite = 0;
  logic [1:0] cfgSel = 0;
  logic [31:0] cfgKey = 0, cfgWdata = 0, cfgRdata;
  logic cfgFault;
  logic [31:0] bpAddr = BPA;
  logic [1:0] bpKind = T_X;
  logic bpLocalEn = 0, bpGlobalEn = 0, dbgExtEn = 0;
  logic accValid = 0, accWrite = 0;
  logic [31:0] accAddr = 0, accData = 0;
  logic [1:0] accKind = 0;
  logic hit;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; bit exp; string tag; } itemT;
  itemT q[$];
  itemT cur;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bp_match_unit u_dut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgKey(cfgKey), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfgFault(cfgFault),
    .bpAddr(bpAddr), .bpKind(bpKind), .bpLocalEn(bpLocalEn), .bpGlobalEn(bpGlobalEn),
    .dbgExtEn(dbgExtEn), .accValid(accValid), .accAddr(accAddr), .accData(accData),
    .accKind(accKind), .accWrite(accWrite), .hit(hit)
  );

  task automatic checkVal(logic [31:0] got, logic [31:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // monitor: pops expected hit values when they fall due, idle cycles must be low
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        cur = q.pop_front();
        checkVal({31'b0, hit}, {31'b0, cur.exp}, cur.tag);
      end else if (hit !== 1'b0) begin
        checkVal({31'b0, hit}, 32'h0, "R12 stray or stretched pulse");
      end
    end
  end

  task automatic acc(logic [31:0] a, logic [31:0] d, logic [1:0] k, bit wr, bit exp, string tag);
    itemT it;
    @(negedge clk);
    accValid = 1; accAddr = a; accData = d; accKind = k; accWrite = wr;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accValid = 0;
    end
  endtask

  task automatic setBp(logic [1:0] t, bit l, bit g, bit e);
    @(negedge clk);
    accValid = 0; bpKind = t; bpLocalEn = l; bpGlobalEn = g; dbgExtEn = e;
  endtask

  task automatic cfgOp(bit wr, logic [1:0] sel, logic [31:0] key, logic [31:0] wd,
                       bit expFault, logic [31:0] expRd, string tag);
    @(negedge clk);
    accValid = 0;
    cfgValid = 1; cfgWrite = wr; cfgSel = sel; cfgKey = key; cfgWdata = wd;
    @(posedge clk);
    #1;
    checkVal({31'b0, cfgFault}, {31'b0, expFault}, {tag, " fault"});
    if (!wr) checkVal(cfgRdata, expRd, {tag, " rdata"});
    @(negedge clk);
    cfgValid = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] v);
    cfgOp(1, sel, KEY, v, 0, 0, "R2 keyed write");
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values
    #1 checkVal({31'b0, hit}, 32'h0, "R1 hit low after reset");
    for (int s = 0; s < 4; s++) cfgOp(0, 2'(s), KEY, 0, 0, 32'h0, "R1 reset register");
    // R2 key gate
    cfgOp(1, 2'd0, 32'h1234_5678, 32'h2, 1, 0, "R2 bad-key write");
    cfgOp(0, 2'd0, KEY, 0, 0, 32'h0, "R2 mode unchanged after bad key");
    wr(2'd1, MV);
    cfgOp(0, 2'd1, 32'h0, 0, 1, 32'h0, "R2 bad-key read");
    cfgOp(0, 2'd1, KEY, 0, 0, MV, "R2 good-key readback");
    wr(2'd3, 32'hFFFF_FFFF);
    cfgOp(0, 2'd3, KEY, 0, 0, 32'h0000_0FFF, "R2 address mask zero-extended");
    wr(2'd3, 0);

    // execute breakpoint
    setBp(T_X, 1, 0, 0);
    acc(BPA, 0, K_F, 0, 1, "R5 fetch exact");
    acc(BPA + 1, 0, K_F, 0, 0, "R3 zero mask needs exact");
    acc(BPA, 0, K_M, 1, 0, "R13 memory event on execute bp");
    idle(2);
    wr(2'd3, 32'h00F);
    acc(32'h0001_234F, 0, K_F, 0, 1, "R3 inside masked window");
    acc(32'h0001_2350, 0, K_F, 0, 0, "R3 outside masked window");
    idle(2);
    wr(2'd3, 32'hFFF);
    acc(32'h0001_2FFF, 0, K_F, 0, 1, "R3 4096 window top");
    acc(32'h0001_3000, 0, K_F, 0, 0, "R3 next block");
    idle(2);
    wr(2'd3, 0);
    wr(2'd0, 3);
    acc(BPA, 32'h0, K_F, 0, 1, "R5 mode and data ignored for execute");
    idle(2);
    wr(2'd0, 0);
    setBp(T_X, 0, 0, 0);
    acc(BPA, 0, K_F, 0, 0, "R4 both enables off");
    idle(2);
    setBp(T_X, 0, 1, 0);
    acc(BPA, 0, K_F, 0, 1, "R4 global enable alone");
    idle(2);

    // memory, legacy mode
    setBp(T_W, 1, 0, 0);
    acc(BPA, 0, K_M, 1, 1, "R6 write-type bp on write");
    acc(BPA, 0, K_M, 0, 0, "R6 write-type bp on read");
    idle(2);
    setBp(T_RW, 1, 0, 0);
    acc(BPA, 0, K_M, 0, 1, "R6 rw-type bp on read");
    acc(BPA, 0, K_M, 1, 1, "R6 rw-type bp on write");
    acc(BPA, 0, K_F, 0, 0, "R13 fetch on memory bp");
    idle(2);

    // mode 2 / 3
    wr(2'd0, 2);
    acc(BPA, MV, K_M, 0, 0, "R7 read ignored");
    acc(BPA, MV, K_M, 1, 1, "R7 write data match");
    acc(BPA, MV ^ 32'h1, K_M, 1, 0, "R7 write data mismatch");
    acc(BPA + 4, MV, K_M, 1, 0, "R7 address still compared");
    idle(2);
    wr(2'd2, 32'hFFFF_FFFF);
    acc(BPA, 32'h0, K_M, 1, 1, "R3 all-ones data mask");
    idle(2);
    wr(2'd2, 0);
    wr(2'd0, 3);
    acc(BPA, MV ^ 32'h1, K_M, 1, 1, "R8 mismatch hits");
    acc(BPA, MV, K_M, 1, 0, "R8 match misses");
    idle(2);

    // mode 1
    wr(2'd0, 1);
    acc(32'h8000_0000, MV, K_M, 1, 1, "R9 any address write match");
    acc(32'h8000_0000, MV, K_M, 0, 0, "R9 read ignored");
    acc(32'h8000_0000, 32'h0, K_M, 1, 0, "R9 data mismatch");
    idle(2);
    wr(2'd2, 32'hFF);
    acc(32'h0000_0005, 32'hDEAD_BE00, K_M, 1, 1, "R3 partial data mask");
    idle(2);
    wr(2'd2, 0);

    // bit 3 aliasing on memory
    wr(2'd0, 8);
    acc(BPA, 32'h0, K_M, 0, 1, "R11 mode 8 acts as 0 on read");
    acc(32'h0009_9999, 32'h0, K_M, 0, 0, "R11 mode 8 keeps address");
    idle(2);
    wr(2'd0, 9);
    acc(32'h7000_0000, MV, K_M, 1, 1, "R11 mode 9 acts as 1");
    idle(2);

    // I/O
    wr(2'd0, 0);
    setBp(T_IO, 1, 0, 0);
    acc(BPA, 0, K_I, 0, 0, "R4 io needs extensions enable");
    idle(2);
    setBp(T_IO, 1, 0, 1);
    acc(BPA, 0, K_I, 0, 1, "R6 io legacy read");
    acc(BPA, 0, K_I, 1, 1, "R6 io legacy write");
    acc(BPA, 0, K_M, 1, 0, "R13 memory event on io bp");
    idle(2);
    wr(2'd0, 8);
    acc(BPA, MV, K_I, 0, 1, "R10 mode 8 read match");
    acc(BPA, MV, K_I, 1, 0, "R10 mode 8 write ignored");
    acc(BPA, 32'h0, K_I, 0, 0, "R10 mode 8 read mismatch");
    acc(BPA + 2, MV, K_I, 0, 0, "R10 mode 8 address applied");
    idle(2);
    wr(2'd0, 9);
    acc(BPA, 32'h0, K_I, 0, 1, "R10 mode 9 read mismatch");
    acc(BPA, MV, K_I, 0, 0, "R10 mode 9 read match");
    idle(2);
    wr(2'd0, 32'h0A);
    acc(BPA, 32'h0, K_I, 0, 1, "R12 unlisted io mode acts as legacy");
    idle(2);

    // unlisted mode on memory, back-to-back pulses
    wr(2'd0, 5);
    setBp(T_W, 1, 0, 0);
    acc(BPA, 32'h0, K_M, 1, 1, "R12 unlisted mode write");
    acc(BPA, 32'h0, K_M, 0, 0, "R12 unlisted mode read");
    idle(2);
    wr(2'd0, 0);
    setBp(T_RW, 1, 0, 0);
    acc(BPA, 0, K_M, 0, 1, "R12 back-to-back first");
    acc(BPA, 0, K_M, 1, 1, "R12 back-to-back second");
    idle(4);
    done = 1;
    finishRun();
  end
endmodule